// File: doc/BRIEF.md
# Demand-Paged Graphics Address Translator

Every memory client of the graphics core passes its 34-bit logical byte address through this block, which returns the matching physical address in local memory. Pages are 4 KB, so the low 12 bits pass through unchanged and the upper 22 bits form the virtual page number (VPN). Each page maps on its own, so consecutive logical pages may land on scattered physical pages. A small fully associative translation cache answers repeat accesses in one cycle.

On a cache miss the block reads a 32-bit page-table word from `pt_base + VPN*4`. If that word marks the page as present, its frame number is loaded into the cache and the request completes. If the page is absent, local memory is missing it, and the block asks a host-side copy engine to bring it in. It does this by raising `fault_req` with the VPN and waiting for `fault_done`, then it reads the page-table word again. Only one miss is handled at a time. The requester sees `req_ready` low while the miss is being resolved.

The control is a four-state machine. **IDLE** accepts requests. A hit stays in IDLE. A miss, or a request that arrives together with an invalidate, goes to **PT_ISSUE**. PT_ISSUE pulses the page-table read and always goes on to **PT_WAIT**. PT_WAIT waits for the read data. From there, a stale result (an invalidate was seen after the read was issued) goes back to PT_ISSUE. A present page goes back to IDLE with the response. An absent page goes to **FAULT**. FAULT holds the fault request until `fault_done` and then goes back to PT_ISSUE.

Top module: `gfx_page_xlate`

## Requirements
- R1: A request accepted while its VPN is cached and `inval` is low produces `rsp_valid` on the next cycle with `rsp_paddr = {cached frame, offset}`, and no page-table read is issued.
- R2: A miss issues exactly one single-cycle `pt_rd_req` with `pt_rd_addr = pt_base + VPN*4` before the response, unless R4 or R7 forces a further read.
- R3: A page-table word with bit 31 set is a present page; the request completes with `rsp_paddr = {word[19:0], offset}`, and a later request to that VPN hits.
- R4: A page-table word with bit 31 clear raises `fault_req` with `fault_vpn` = VPN, held steady until `fault_done`; the word is then read again and the request completes from the new word.
- R5: After a miss is accepted, `req_ready` stays low every cycle until the cycle in which `rsp_valid` is high.
- R6: A pulse on `inval` removes every cached translation; the next request to any previously cached VPN misses.
- R7: If `inval` is high at any point after a page-table read is issued and before its data is used, that data is discarded and the word is read again; the response uses the second word.
- R8: A request accepted in the same cycle as `inval` is treated as a miss, even if its VPN was cached.
- R9: The cache holds 8 translations, with no VPN held twice, and replaces them round-robin: after an invalidate and 9 distinct misses the first VPN is gone and the second still hits.
- R10: During and straight after reset `req_ready` is 1, and `rsp_valid`, `pt_rd_req` and `fault_req` are 0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval | input | 1 | Drop all cached translations |
| pt_base | input | 32 | Byte address of page-table entry for VPN 0 |
| req_valid | input | 1 | Translation request present |
| req_laddr | input | 34 | Logical byte address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Single-cycle pulse, physical address valid |
| rsp_paddr | output | 32 | Physical byte address |
| pt_rd_req | output | 1 | Page-table read pulse |
| pt_rd_addr | output | 32 | Page-table word address |
| pt_rd_valid | input | 1 | Page-table read data valid |
| pt_rd_data | input | 32 | Page-table word (bit 31 present, bits 19:0 frame) |
| fault_req | output | 1 | Page not present, fetch requested |
| fault_vpn | output | 22 | Page number to fetch |
| fault_done | input | 1 | Fetch finished |

## Verification
On every cycle the assertions check several things. A hit is answered one cycle later with the cached frame. The page-table read is a single pulse. The fault request and its VPN stay steady until `fault_done`, and no response or read happens during a fault. `req_ready` only rises together with a response. A stale page-table word always leads to a re-read. A request that meets an invalidate never completes as a hit. The cache never matches a VPN twice, and it is empty one cycle after an invalidate. The bench scenarios are needed for the rest. These are the end-to-end address values, and the number of page-table reads and faults for each request. They also include the round-robin eviction order, and the case where a mapping changed mid-lookup and only the re-read value may appear.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_PT_ISSUE = 2'd1,
        S_PT_WAIT  = 2'd2,
        S_FAULT    = 2'd3
    } walk_state_t;
endpackage

// File: rtl/gpx_xlate_cache.sv
module gpx_xlate_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 22,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] match;
    logic [PPN_W-1:0]   ppn_sel [ENTRIES];
    logic [IDX_W-1:0]   victim_q;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            logic             v_q;
            logic [VPN_W-1:0] tag_q;
            logic [PPN_W-1:0] frame_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q     <= 1'b0;
                    tag_q   <= '0;
                    frame_q <= '0;
                end else if (flush) begin
                    v_q <= 1'b0;
                end else if (fill_en && victim_q == IDX_W'(g)) begin
                    v_q     <= 1'b1;
                    tag_q   <= fill_vpn;
                    frame_q <= fill_ppn;
                end
            end

            assign match[g]   = v_q && (tag_q == look_vpn);
            assign ppn_sel[g] = match[g] ? frame_q : '0;
        end
    endgenerate

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) hit_ppn |= ppn_sel[i];
    end
    assign hit = |match;

    // Round-robin victim pointer, rewound by a flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       victim_q <= '0;
        else if (flush)   victim_q <= '0;
        else if (fill_en) victim_q <= (victim_q == IDX_W'(ENTRIES-1)) ? '0 : victim_q + 1'b1;
    end

    p_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/gfx_page_xlate.sv
module gfx_page_xlate
    import gpx_pkg::*;
#(
    parameter int VA_W    = 34,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 8,
    parameter int PT_AW   = 32,
    parameter int RES_BIT = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inval,
    input  logic [PT_AW-1:0]       pt_base,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_laddr,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr,
    output logic                   pt_rd_req,
    output logic [PT_AW-1:0]       pt_rd_addr,
    input  logic                   pt_rd_valid,
    input  logic [31:0]            pt_rd_data,
    output logic                   fault_req,
    output logic [VA_W-OFF_W-1:0]  fault_vpn,
    input  logic                   fault_done
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    walk_state_t      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             stale_q;
    logic             rsp_valid_q;
    logic [PA_W-1:0]  rsp_paddr_q;

    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             pte_present;
    logic             fill_en;
    logic             unused_pte_bits;

    assign pte_present     = pt_rd_data[RES_BIT];
    assign unused_pte_bits = ^pt_rd_data[RES_BIT-1:PPN_W];
    assign fill_en         = (state_q == S_PT_WAIT) && pt_rd_valid && pte_present
                             && !stale_q && !inval;

    gpx_xlate_cache #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (inval),
        .look_vpn (req_laddr[VA_W-1:OFF_W]),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .fill_en  (fill_en),
        .fill_vpn (vpn_q),
        .fill_ppn (pt_rd_data[PPN_W-1:0])
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid && !(hit && !inval)) state_d = S_PT_ISSUE;
            S_PT_ISSUE: state_d = S_PT_WAIT;
            S_PT_WAIT: begin
                if (pt_rd_valid) begin
                    if (stale_q || inval) state_d = S_PT_ISSUE;
                    else if (pte_present) state_d = S_IDLE;
                    else                  state_d = S_FAULT;
                end
            end
            S_FAULT:    if (fault_done) state_d = S_PT_ISSUE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, staleness tracking and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            off_q       <= '0;
            stale_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_paddr_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (state_q == S_IDLE && req_valid) begin
                vpn_q <= req_laddr[VA_W-1:OFF_W];
                off_q <= req_laddr[OFF_W-1:0];
                if (hit && !inval) begin
                    rsp_valid_q <= 1'b1;
                    rsp_paddr_q <= {hit_ppn, req_laddr[OFF_W-1:0]};
                end
            end
            if (state_q == S_PT_ISSUE)           stale_q <= inval;
            else if (state_q == S_PT_WAIT && inval) stale_q <= 1'b1;
            if (fill_en) begin
                rsp_valid_q <= 1'b1;
                rsp_paddr_q <= {pt_rd_data[PPN_W-1:0], off_q};
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        pt_rd_req  = (state_q == S_PT_ISSUE);
        fault_req  = (state_q == S_FAULT);
        fault_vpn  = vpn_q;
        pt_rd_addr = pt_base + PT_AW'({vpn_q, 2'b00});
        rsp_valid  = rsp_valid_q;
        rsp_paddr  = rsp_paddr_q;
    end

    p_hit_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit && !inval)
        |=> rsp_valid && rsp_paddr[PA_W-1:OFF_W] == $past(hit_ppn));

    p_ptrd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_req |=> !pt_rd_req);

    p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_req && !fault_done) |=> fault_req && $stable(fault_vpn));

    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> !rsp_valid && !pt_rd_req);

    p_ready_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> rsp_valid);

    p_stale_reread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PT_WAIT && pt_rd_valid && (stale_q || inval)) |=> pt_rd_req);

    p_inval_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && inval) |=> !rsp_valid);
endmodule

// File: tb/gfx_page_xlate_test.sv
`timescale 1ns/1ps
module gfx_page_xlate_test;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inval = 1'b0;
    logic [31:0] pt_base = BASE;
    logic        req_valid = 1'b0;
    logic [33:0] req_laddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        pt_rd_req;
    logic [31:0] pt_rd_addr;
    logic        pt_rd_valid = 1'b0;
    logic [31:0] pt_rd_data = '0;
    logic        fault_req;
    logic [21:0] fault_vpn;
    logic        fault_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int fault_cnt = 0;
    int fault_drop = 0;
    int last_fault_vpn = -1;
    logic [31:0] last_rd_addr = '0;
    bit finished = 0;

    logic [31:0] pte_mem [int];
    int model_q[$];

    always #10 clk = ~clk;

    gfx_page_xlate uut (
        .clk(clk), .rst_n(rst_n), .inval(inval), .pt_base(pt_base),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .pt_rd_req(pt_rd_req), .pt_rd_addr(pt_rd_addr),
        .pt_rd_valid(pt_rd_valid), .pt_rd_data(pt_rd_data),
        .fault_req(fault_req), .fault_vpn(fault_vpn), .fault_done(fault_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [19:0] frame_of(input int vpn);
        return 20'((vpn * 37 + 5) & 32'h000F_FFFF);
    endfunction

    task automatic set_page(input int vpn, input bit present);
        pte_mem[vpn] = {present, 11'd0, frame_of(vpn)};
    endtask

    function automatic bit model_hit(input int vpn);
        foreach (model_q[i]) if (model_q[i] == vpn) return 1;
        return 0;
    endfunction

    task automatic model_fill(input int vpn);
        model_q.push_back(vpn);
        if (model_q.size() > 8) void'(model_q.pop_front());
    endtask

    // Page-table memory: captures the word when the read is issued
    initial begin
        forever begin
            @(negedge clk);
            pt_rd_valid = 1'b0;
            if (pt_rd_req) begin
                int v;
                logic [31:0] d;
                rd_cnt++;
                last_rd_addr = pt_rd_addr;
                v = int'((pt_rd_addr - BASE) >> 2);
                d = pte_mem.exists(v) ? pte_mem[v] : 32'h0;
                repeat (2) @(negedge clk);
                pt_rd_valid = 1'b1;
                pt_rd_data  = d;
            end
        end
    end

    // Host copy engine: makes the page present and reports completion
    initial begin
        forever begin
            @(negedge clk);
            fault_done = 1'b0;
            if (fault_req) begin
                int v;
                v = int'(fault_vpn);
                fault_cnt++;
                last_fault_vpn = v;
                repeat (3) begin
                    @(negedge clk);
                    if (!fault_req || int'(fault_vpn) != v) fault_drop++;
                end
                pte_mem[v][31] = 1'b1;
                fault_done = 1'b1;
            end
        end
    end

    task automatic wait_rsp(input string req);
        int n = 0;
        while (!rsp_valid && n < 300) begin
            chk(req_ready == 1'b0, "R5 ready low during miss", req_ready, 0);
            @(negedge clk);
            n++;
        end
        chk(rsp_valid == 1'b1, req, rsp_valid, 1);
    endtask

    // One request; returns number of page-table reads it caused
    task automatic run_req(input int vpn, input logic [11:0] off, input bit with_inval,
                           input string req, output int reads);
        bit exp_hit;
        int rd0;
        logic [31:0] exp_pa;
        rd0 = rd_cnt;
        @(negedge clk);
        if (with_inval) model_q.delete();
        exp_hit = model_hit(vpn);
        chk(req_ready == 1'b1, "R5 ready in idle", req_ready, 1);
        req_valid = 1'b1;
        req_laddr = {vpn[21:0], off};
        inval     = with_inval;
        @(negedge clk);
        req_valid = 1'b0;
        inval     = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid == 1'b1, "R1 hit answers next cycle", rsp_valid, 1);
        end else begin
            chk(rsp_valid == 1'b0, {req, " miss not immediate"}, rsp_valid, 0);
            wait_rsp(req);
            model_fill(vpn);
        end
        exp_pa = {pte_mem[vpn][19:0], off};
        chk(rsp_paddr == exp_pa, {req, " paddr"}, rsp_paddr, exp_pa);
        reads = rd_cnt - rd0;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval = 1'b1;
        model_q.delete();
        @(negedge clk);
        inval = 1'b0;
    endtask

    initial begin
        int r;
        int f0;
        for (int v = 0; v < 200; v++) set_page(v, 1'b1);
        set_page(50, 1'b0);
        set_page(22'h3FFFFF, 1'b1);

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 reset ready/rsp", {req_ready, rsp_valid}, 2'b10);
        chk(pt_rd_req == 1'b0 && fault_req == 1'b0, "R10 reset read/fault", {pt_rd_req, fault_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && pt_rd_req == 1'b0 && fault_req == 1'b0,
            "R10 after reset", {req_ready, rsp_valid, pt_rd_req, fault_req}, 4'b1000);

        // R2, R3: first access misses, reads the right word
        run_req(10, 12'h123, 0, "R3 miss completes", r);
        chk(r == 1, "R2 one read per miss", r, 1);
        chk(last_rd_addr == BASE + 32'd40, "R2 read address", last_rd_addr, BASE + 32'd40);

        // R1: repeat hits
        run_req(10, 12'hABC, 0, "R1 hit", r);
        chk(r == 0, "R1 no read on hit", r, 0);
        run_req(11, 12'h001, 0, "R3 miss 11", r);
        run_req(12, 12'hFFF, 0, "R3 miss 12", r);
        run_req(11, 12'h777, 0, "R1 hit 11", r);
        chk(r == 0, "R1 no read on hit 11", r, 0);

        // R4: absent page faults, then re-reads
        f0 = fault_cnt;
        run_req(50, 12'h050, 0, "R4 fault completes", r);
        chk(fault_cnt - f0 == 1, "R4 one fault", fault_cnt - f0, 1);
        chk(last_fault_vpn == 50, "R4 fault vpn", last_fault_vpn, 50);
        chk(fault_drop == 0, "R4 fault held", fault_drop, 0);
        chk(r == 2, "R4 reread after fault", r, 2);
        run_req(50, 12'h051, 0, "R3 filled after fault hits", r);
        chk(r == 0, "R3 no read after fill", r, 0);

        // R6: invalidate empties the cache
        pulse_inval();
        run_req(10, 12'h010, 0, "R6 miss after invalidate", r);
        chk(r == 1, "R6 read after invalidate", r, 1);

        // R8: request together with invalidate misses
        run_req(10, 12'h020, 1, "R8 request with invalidate", r);
        chk(r == 1, "R8 read on coincident invalidate", r, 1);

        // R7: invalidate during an outstanding read forces a second read
        begin
            int rd0;
            logic [31:0] exp_pa;
            rd0 = rd_cnt;
            @(negedge clk);
            req_valid = 1'b1;
            req_laddr = {22'd12, 12'h3C4};
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            inval = 1'b1;
            model_q.delete();
            pte_mem[12] = {1'b1, 11'd0, 20'hBEEF1};
            @(negedge clk);
            inval = 1'b0;
            wait_rsp("R7 completes after stale read");
            model_fill(12);
            exp_pa = {20'hBEEF1, 12'h3C4};
            chk(rsp_paddr == exp_pa, "R7 uses re-read word", rsp_paddr, exp_pa);
            chk(rd_cnt - rd0 == 2, "R7 two reads", rd_cnt - rd0, 2);
        end

        // R9: round-robin over 8 entries
        pulse_inval();
        for (int v = 100; v < 109; v++) run_req(v, 12'(v), 0, "R9 fill", r);
        run_req(101, 12'h101, 0, "R9 second still cached", r);
        chk(r == 0, "R9 second hits", r, 0);
        run_req(100, 12'h100, 0, "R9 first evicted", r);
        chk(r == 1, "R9 first misses", r, 1);

        // R3: top of address space
        run_req(22'h3FFFFF, 12'hFFF, 0, "R3 top page", r);
        chk(r == 1, "R2 top page read", r, 1);
        chk(last_rd_addr == BASE + 32'h00FF_FFFC, "R2 top read address", last_rd_addr, BASE + 32'h00FF_FFFC);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule